// File: doc/BRIEF.md
# Local Interrupt Priority Arbiter

This block is the prioritisation core of a per-processor interrupt controller. It keeps three 256-bit vectors: pending requests, requests in service, and the trigger mode of each request. It also keeps an 8-bit task priority and a 9-bit spurious/enable register. Sources post a vector number together with its trigger mode. The block raises an interrupt line toward the core whenever the best pending request outranks the current processor priority.

The core acknowledges with a one-cycle strobe and reads the returned vector in that same cycle. It retires the handler by writing the end-of-interrupt register. Software reaches the registers through a 32-bit access port, and the register index is taken from address bits 11:4.

Top module: `irq_prio_arbiter`

## Requirements
- R1: `irqOut` is high exactly when all of the following hold: spurious register bit 8 is set, at least one request is pending, and either the processor priority is 0 or the upper nibble of the highest pending vector is greater than the upper nibble of the processor priority. It reflects register state with no added delay.
- R2: The processor priority is read at index 0x0A. It equals the task priority when the task priority's upper nibble is at least the class (vector >> 4) of the highest in-service vector, where that class counts as 0 when nothing is in service. Otherwise it equals that class shifted left by 4.
- R3: While `ackStrobe` is high, if the acknowledge is not spurious, `ackVector` shows the highest-numbered pending vector. At the clock edge that vector's pending bit clears and its in-service bit sets.
- R4: An acknowledge is spurious in three cases: the block is software-disabled, nothing is pending, or the task priority is nonzero and the highest pending vector is at or below it. A spurious acknowledge returns spurious register bits 7:0 and changes no pending or in-service bit.
- R5: Any write to index 0x0B clears the highest-numbered in-service bit. When nothing is in service the write has no effect.
- R6: Posting a request sets its pending bit. It also sets the trigger bit when `reqLevel` is 1 (level) and clears it when `reqLevel` is 0 (edge). Word w of each vector holds vectors 32w..32w+31, and vector v sits at bit v%32. The in-service words are at indices 0x10+w, the trigger words at 0x18+w and the pending words at 0x20+w.
- R7: The task priority at index 0x08 is 8 bits wide and reads back what was written. A write to the spurious register at index 0x0F keeps bits 8:0.
- R8: Writes to indices 0x0A, 0x10 to 0x27 and 0x28 change nothing.
- R9: A read or write at any index other than 0x08, 0x0A, 0x0B, 0x0F, 0x10 to 0x28 sets bit 7 of the error word at index 0x28. The bit stays set. An access at a defined index leaves it unchanged.
- R10: After reset the task priority is 0, all three vectors are 0, the error word is 0, the spurious register is 0xFF (software-disabled) and `irqOut` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Post a request this cycle |
| reqVector | input | 8 | Vector number of the request |
| reqLevel | input | 1 | 1 = level trigger, 0 = edge trigger |
| ackStrobe | input | 1 | Single-cycle acknowledge from the core |
| ackVector | output | 8 | Vector returned during the acknowledge cycle |
| irqOut | output | 1 | Interrupt line to the core |
| busSel | input | 1 | Register access this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte address; bits 11:4 select the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the access cycle |

## Verification
The assertions assume a few things about the inputs:
- A request and an acknowledge never name the same vector in the same cycle.
- `busSel` is high for a single cycle per access.
- Every input is stable around the rising edge.

The bench drives each strobe for exactly one cycle between falling edges. It never posts a request while an acknowledge is in flight, and it waits for every effect to settle before it reads.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int VEC_NUM  = 256;
  localparam int VEC_W    = $clog2(VEC_NUM);
  localparam int WORD_W   = 32;
  localparam int WORD_CNT = VEC_NUM / WORD_W;
  localparam int WIDX_W   = $clog2(WORD_CNT);

  typedef struct packed {
    logic setReq;
    logic ackTake;
    logic eoiClear;
    logic tprWr;
    logic svrWr;
    logic errSet;
  } ctrlStrobes_t;
endpackage

// File: rtl/irq_prio_encoder.sv
module irq_prio_encoder #(
  parameter int WIDTH = 256,
  localparam int IDX_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] vecIn,
  output logic [IDX_W-1:0] topIdx,
  output logic             noneSet
);
  always_comb begin
    topIdx = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (vecIn[i]) topIdx = IDX_W'(i);
    end
  end
  assign noneSet = ~|vecIn;
endmodule

// File: rtl/irq_prio_datapath.sv
module irq_prio_datapath
  import irq_prio_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strb,
  input  logic [VEC_W-1:0]   reqVector,
  input  logic               reqLevel,
  input  logic [31:0]        busWdata,
  input  logic [WIDX_W-1:0]  wordIdx,
  output logic [VEC_W-1:0]   irrTop,
  output logic               irrNone,
  output logic [VEC_W-1:0]   isrTop,
  output logic               isrNone,
  output logic [7:0]         tprReg,
  output logic [8:0]         svrReg,
  output logic [7:0]         esrReg,
  output logic [WORD_W-1:0]  irrWord,
  output logic [WORD_W-1:0]  isrWord,
  output logic [WORD_W-1:0]  tmrWord
);
  logic [VEC_NUM-1:0] irrVec, isrVec, tmrVec;
  logic [VEC_NUM-1:0] setMask, ackMask, eoiMask;

  irq_prio_encoder #(.WIDTH(VEC_NUM)) irrEnc_i (.vecIn(irrVec), .topIdx(irrTop), .noneSet(irrNone));
  irq_prio_encoder #(.WIDTH(VEC_NUM)) isrEnc_i (.vecIn(isrVec), .topIdx(isrTop), .noneSet(isrNone));

  assign setMask = strb.setReq ? (VEC_NUM'(1) << reqVector) : '0;
  assign ackMask = strb.ackTake ? (VEC_NUM'(1) << irrTop) : '0;
  assign eoiMask = (strb.eoiClear && !isrNone) ? (VEC_NUM'(1) << isrTop) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irrVec <= '0;
      isrVec <= '0;
      tmrVec <= '0;
      tprReg <= 8'h00;
      svrReg <= 9'h0FF;
      esrReg <= 8'h00;
    end else begin
      irrVec <= (irrVec & ~ackMask) | setMask;
      isrVec <= (isrVec & ~eoiMask) | ackMask;
      if (strb.setReq) tmrVec[reqVector] <= reqLevel;
      if (strb.tprWr) tprReg <= busWdata[7:0];
      if (strb.svrWr) svrReg <= busWdata[8:0];
      if (strb.errSet) esrReg[7] <= 1'b1;
    end
  end

  assign irrWord = irrVec[wordIdx*WORD_W +: WORD_W];
  assign isrWord = isrVec[wordIdx*WORD_W +: WORD_W];
  assign tmrWord = tmrVec[wordIdx*WORD_W +: WORD_W];

  // R3
  ack_moves_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.ackTake && !strb.setReq && !strb.eoiClear |=> isrVec[$past(irrTop)] && !irrVec[$past(irrTop)]);
  // R4
  irr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.setReq && !strb.ackTake |=> $stable(irrVec));
  // R5
  eoi_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.eoiClear && !isrNone && !strb.ackTake |=> !isrVec[$past(isrTop)]);
  // R6
  tmr_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.setReq |=> (tmrVec[$past(reqVector)] == $past(reqLevel)) && irrVec[$past(reqVector)]);
  // R9
  esr_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    esrReg[7] |=> esrReg[7]);
endmodule

// File: rtl/irq_prio_control.sv
module irq_prio_control
  import irq_prio_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               ackStrobe,
  input  logic               busSel,
  input  logic               busWrite,
  input  logic [11:0]        busAddr,
  input  logic [VEC_W-1:0]   irrTop,
  input  logic               irrNone,
  input  logic [VEC_W-1:0]   isrTop,
  input  logic               isrNone,
  input  logic [7:0]         tprReg,
  input  logic [8:0]         svrReg,
  input  logic [7:0]         esrReg,
  input  logic [WORD_W-1:0]  irrWord,
  input  logic [WORD_W-1:0]  isrWord,
  input  logic [WORD_W-1:0]  tmrWord,
  output ctrlStrobes_t       strb,
  output logic [WIDX_W-1:0]  wordIdx,
  output logic [VEC_W-1:0]   ackVector,
  output logic               irqOut,
  output logic [31:0]        busRdata
);
  typedef enum logic [3:0] {
    SEL_NONE, SEL_TPR, SEL_PPR, SEL_EOI, SEL_SVR, SEL_ISR, SEL_TMR, SEL_IRR, SEL_ESR
  } regSel_t;

  logic [7:0] regIdx;
  regSel_t    regSel;
  logic [7:0] pprVal;
  logic [3:0] isrClass;
  logic       swEnable, spurious;

  assign regIdx  = busAddr[11:4];
  assign wordIdx = regIdx[WIDX_W-1:0];

  always_comb begin
    regSel = SEL_NONE;
    unique casez (regIdx)
      8'h08:       regSel = SEL_TPR;
      8'h0A:       regSel = SEL_PPR;
      8'h0B:       regSel = SEL_EOI;
      8'h0F:       regSel = SEL_SVR;
      8'b0001_0???: regSel = SEL_ISR;
      8'b0001_1???: regSel = SEL_TMR;
      8'b0010_0???: regSel = SEL_IRR;
      8'h28:       regSel = SEL_ESR;
      default:     regSel = SEL_NONE;
    endcase
  end

  assign isrClass = isrNone ? 4'h0 : isrTop[7:4];
  assign pprVal   = (tprReg[7:4] >= isrClass) ? tprReg : {isrClass, 4'h0};
  assign swEnable = svrReg[8];
  assign irqOut   = swEnable && !irrNone && ((pprVal == 8'h00) || (irrTop[7:4] > pprVal[7:4]));
  assign spurious = !swEnable || irrNone || ((tprReg != 8'h00) && (irrTop <= tprReg));
  assign ackVector = (ackStrobe && !spurious) ? irrTop : svrReg[7:0];

  always_comb begin
    strb          = '0;
    strb.setReq   = reqValid;
    strb.ackTake  = ackStrobe && !spurious;
    strb.eoiClear = busSel && busWrite && (regSel == SEL_EOI);
    strb.tprWr    = busSel && busWrite && (regSel == SEL_TPR);
    strb.svrWr    = busSel && busWrite && (regSel == SEL_SVR);
    strb.errSet   = busSel && (regSel == SEL_NONE);
  end

  always_comb begin
    busRdata = 32'h0;
    case (regSel)
      SEL_TPR: busRdata = {24'h0, tprReg};
      SEL_PPR: busRdata = {24'h0, pprVal};
      SEL_SVR: busRdata = {23'h0, svrReg};
      SEL_ISR: busRdata = isrWord;
      SEL_TMR: busRdata = tmrWord;
      SEL_IRR: busRdata = irrWord;
      SEL_ESR: busRdata = {24'h0, esrReg};
      default: busRdata = 32'h0;
    endcase
  end

  // R1
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> svrReg[8] && !irrNone);
  // R4
  spurious_vec_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackStrobe && !strb.ackTake |-> ackVector == svrReg[7:0]);
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
  import irq_prio_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [7:0]  reqVector,
  input  logic        reqLevel,
  input  logic        ackStrobe,
  output logic [7:0]  ackVector,
  output logic        irqOut,
  input  logic        busSel,
  input  logic        busWrite,
  input  logic [11:0] busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata
);
  ctrlStrobes_t      strb;
  logic [WIDX_W-1:0] wordIdx;
  logic [VEC_W-1:0]  irrTop, isrTop;
  logic              irrNone, isrNone;
  logic [7:0]        tprReg, esrReg;
  logic [8:0]        svrReg;
  logic [WORD_W-1:0] irrWord, isrWord, tmrWord;

  irq_prio_datapath dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .reqVector(reqVector), .reqLevel(reqLevel),
    .busWdata(busWdata), .wordIdx(wordIdx), .irrTop(irrTop), .irrNone(irrNone),
    .isrTop(isrTop), .isrNone(isrNone), .tprReg(tprReg), .svrReg(svrReg), .esrReg(esrReg),
    .irrWord(irrWord), .isrWord(isrWord), .tmrWord(tmrWord)
  );

  irq_prio_control ctl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .ackStrobe(ackStrobe), .busSel(busSel),
    .busWrite(busWrite), .busAddr(busAddr), .irrTop(irrTop), .irrNone(irrNone),
    .isrTop(isrTop), .isrNone(isrNone), .tprReg(tprReg), .svrReg(svrReg), .esrReg(esrReg),
    .irrWord(irrWord), .isrWord(isrWord), .tmrWord(tmrWord), .strb(strb), .wordIdx(wordIdx),
    .ackVector(ackVector), .irqOut(irqOut), .busRdata(busRdata)
  );
endmodule

// File: tb/irq_prio_arbiter_tb_top.sv
module irq_prio_arbiter_tb_top;
  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 0, reqLevel = 0, ackStrobe = 0, busSel = 0, busWrite = 0;
  logic [7:0] reqVector = 0;
  logic [11:0] busAddr = 0;
  logic [31:0] busWdata = 0;
  logic [7:0] ackVector;
  logic irqOut;
  logic [31:0] busRdata;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  irq_prio_arbiter dut_i (.*);

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic regRead(input logic [7:0] idx, output logic [31:0] val);
    @(negedge clk);
    busSel = 1; busWrite = 0; busAddr = {idx, 4'h0};
    #5 val = busRdata;
    @(negedge clk);
    busSel = 0;
  endtask

  task automatic regWrite(input logic [7:0] idx, input logic [31:0] val);
    @(negedge clk);
    busSel = 1; busWrite = 1; busAddr = {idx, 4'h0}; busWdata = val;
    @(negedge clk);
    busSel = 0; busWrite = 0;
  endtask

  task automatic expectReg(string tag, logic [7:0] idx, logic [31:0] exp);
    logic [31:0] v;
    regRead(idx, v);
    check(tag, v, exp);
  endtask

  task automatic postReq(input logic [7:0] vec, input logic lvl);
    @(negedge clk);
    reqValid = 1; reqVector = vec; reqLevel = lvl;
    @(negedge clk);
    reqValid = 0;
  endtask

  task automatic doAck(string tag, logic [7:0] exp);
    logic [7:0] v;
    @(negedge clk);
    ackStrobe = 1;
    #5 v = ackVector;
    @(negedge clk);
    ackStrobe = 0;
    check(tag, {24'h0, v}, {24'h0, exp});
  endtask

  task automatic expectIrq(string tag, logic exp);
    @(negedge clk);
    #5 check(tag, {31'h0, irqOut}, {31'h0, exp});
  endtask

  task automatic testReset();
    expectReg("R10 tpr", 8'h08, 0);
    expectReg("R10 svr", 8'h0F, 32'hFF);
    expectReg("R10 esr", 8'h28, 0);
    for (int w = 0; w < 8; w++) begin
      expectReg("R10 irr", 8'h20 + 8'(w), 0);
      expectReg("R10 isr", 8'h10 + 8'(w), 0);
      expectReg("R10 tmr", 8'h18 + 8'(w), 0);
    end
    expectIrq("R10 irq", 0);
  endtask

  task automatic testDisabled();
    postReq(8'h40, 0);
    expectIrq("R1 disabled irq", 0);
    expectReg("R6 irr set", 8'h22, 32'h1);
    doAck("R4 disabled ack", 8'hFF);
    expectReg("R4 irr kept", 8'h22, 32'h1);
    regWrite(8'h0F, 32'hFFFF_FFFF);
    expectReg("R7 svr 9 bits", 8'h0F, 32'h1FF);
    expectIrq("R1 enabled irq", 1);
  endtask

  task automatic testAckEoi();
    postReq(8'h41, 1);
    expectReg("R6 tmr level/edge", 8'h1A, 32'h2);
    expectReg("R6 irr two", 8'h22, 32'h3);
    doAck("R3 ack top", 8'h41);
    expectReg("R3 isr", 8'h12, 32'h2);
    expectReg("R3 irr", 8'h22, 32'h1);
    expectReg("R2 ppr isr class", 8'h0A, 32'h40);
    expectIrq("R1 same class blocked", 0);
    postReq(8'h55, 0);
    expectIrq("R1 higher class", 1);
    doAck("R3 ack 55", 8'h55);
    expectReg("R3 isr two", 8'h12, 32'h0020_0002);
    expectReg("R2 ppr 50", 8'h0A, 32'h50);
    regWrite(8'h0B, 0);
    expectReg("R5 eoi highest", 8'h12, 32'h2);
    expectReg("R2 ppr back", 8'h0A, 32'h40);
    regWrite(8'h0B, 0);
    expectReg("R5 eoi second", 8'h12, 32'h0);
    expectIrq("R1 ppr zero", 1);
  endtask

  task automatic testTpr();
    regWrite(8'h08, 32'h45);
    expectReg("R7 tpr", 8'h08, 32'h45);
    expectReg("R2 ppr tpr", 8'h0A, 32'h45);
    expectIrq("R1 tpr blocks", 0);
    doAck("R4 tpr spurious", 8'hFF);
    expectReg("R4 irr unchanged", 8'h22, 32'h1);
    expectReg("R4 isr unchanged", 8'h12, 32'h0);
    regWrite(8'h08, 32'h30);
    expectIrq("R1 tpr lower", 1);
    doAck("R3 ack over tpr", 8'h40);
    expectReg("R2 ppr class wins", 8'h0A, 32'h40);
    regWrite(8'h0B, 0);
    regWrite(8'h08, 0);
    expectIrq("R1 nothing pending", 0);
    doAck("R4 empty ack", 8'hFF);
  endtask

  task automatic testWords();
    regWrite(8'h0B, 0);
    expectReg("R5 eoi empty", 8'h12, 0);
    postReq(8'h03, 0);
    postReq(8'hF0, 1);
    expectReg("R6 tmr word7", 8'h1F, 32'h0001_0000);
    doAck("R3 ack F0", 8'hF0);
    expectIrq("R1 below F class", 0);
    doAck("R3 ack 03", 8'h03);
    expectReg("R3 isr word0", 8'h10, 32'h8);
    expectReg("R3 isr word7", 8'h17, 32'h0001_0000);
    regWrite(8'h0B, 0);
    expectReg("R5 word7 cleared", 8'h17, 0);
    expectReg("R5 word0 kept", 8'h10, 32'h8);
    regWrite(8'h0B, 0);
    expectReg("R5 word0 cleared", 8'h10, 0);
  endtask

  task automatic testReadOnlyErr();
    regWrite(8'h20, 32'hFFFF_FFFF);
    regWrite(8'h14, 32'hFFFF_FFFF);
    regWrite(8'h0A, 32'hFF);
    regWrite(8'h28, 32'hFF);
    expectReg("R8 irr ro", 8'h20, 0);
    expectReg("R8 isr ro", 8'h14, 0);
    expectReg("R8 ppr ro", 8'h0A, 0);
    expectReg("R9 esr clean", 8'h28, 0);
    expectReg("R9 undefined reads zero", 8'h01, 0);
    expectReg("R9 esr set", 8'h28, 32'h80);
    regWrite(8'h3F, 32'h1);
    expectReg("R9 esr sticky", 8'h28, 32'h80);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    testReset();
    testDisabled();
    testAckEoi();
    testTpr();
    testWords();
    testReadOnlyErr();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2ms;
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule